// File: doc/BRIEF.md
# Serial-Loaded Switch Control Register

This block turns a serial bit stream into on/off commands for eight independent switch channels. A serial clock shifts one data bit per rising edge into an eight-stage shift register. A latch sits between that register and the channel outputs. While its hold input is low the latch is transparent, so the outputs follow the register. On the rising edge of the hold input the latch freezes its contents, and further shifting leaves the outputs alone.

A clear input overrides every other input and turns every channel off. The last register stage appears on a serial output, so several blocks can share one serial clock and hold line with data passed from one to the next. A stream of 8·k bits then loads a chain of k blocks.

All four serial-side inputs are asynchronous to the block. Each is passed through a two-flop synchroniser clocked by a fast system clock, and edges are found by comparing successive synchronised samples. The whole design is therefore synchronous to that one clock.

Top module: `sersw_ctrl`

## Requirements
- R1: The shift register changes only when a rising edge of `sclk_i` is detected. Activity on `sdata_i` while `sclk_i` stays at one level changes neither the register nor `sdo_o`.
- R2: On each rising edge the sampled `sdata_i` bit enters stage 0 and every stage k moves to stage k+1. After eight edges the first bit sent sits in stage 7, and stage n controls `sw_o[n]`, where 1 means on.
- R3: While `latch_hold_i` is low and `clear_i` is low, `sw_o` equals the shift register contents.
- R4: On the rising edge of `latch_hold_i` the switch states are captured. While it stays high, `sw_o` does not change, whatever shifting occurs.
- R5: While `clear_i` is high, `sw_o` is all zero whatever the data, serial clock or hold input do.
- R6: Clear zeroes the latch but keeps the shift register. After clear is released, `sw_o` stays all zero while `latch_hold_i` is high, and follows the register again once `latch_hold_i` is low.
- R7: `sdo_o` is 1 exactly when stage 7 holds 1. When `sdo_o` of one block feeds `sdata_i` of a second block on the same serial clock, a 16-bit stream sent first-bit-first leaves its first eight bits in the second block and its last eight bits in the first block.
- R8: After reset the register and latch are zero, `sw_o` is all zero and `sdo_o` is 0.
- R9: With every serial-side level held for at least four system clock cycles, a change of any input shows on the outputs no more than four system clock cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial shift clock (asynchronous) |
| sdata_i | input | 1 | Serial data in |
| latch_hold_i | input | 1 | Low: latch transparent; rising edge: capture |
| clear_i | input | 1 | High: all switches off, latch zeroed |
| sw_o | output | NUM_CH | Switch commands, 1 = on |
| sdo_o | output | 1 | Last register stage, for chaining |

## Verification
The bench loads a 16-bit stream through two chained blocks with the hold input high. It then checks that nothing reached the switches. A latch that is transparent at the wrong level, or one that captured on each shift, would show data there early. Lowering the hold input must show the exact byte split between the two blocks. A reversed shift direction or a chain off by one bit would place the bytes in the wrong block or mirror them.

Clear is asserted both while the hold input is high and while it is low, and data is shifted during clear. Two faults show up here. A clear that erased the register would break transparency after release. A clear that left the latch intact would make stale bits reappear under hold. The bench also toggles the data input with the serial clock idle, so that a level-triggered shift would be exposed.

// File: rtl/sersw_pkg.sv
package sersw_pkg;

  // positions of the serial-side inputs inside the synchroniser vector
  localparam int IN_SCLK  = 0;
  localparam int IN_SDATA = 1;
  localparam int IN_HOLD  = 2;
  localparam int IN_CLEAR = 3;
  localparam int IN_COUNT = 4;

  // rising edge between two successive synchronised samples
  function automatic logic rose(input logic now_v, input logic was_v);
    return now_v & ~was_v;
  endfunction

  // switch command for one channel from clear, hold, latched and live bits
  function automatic logic chan_cmd(input logic clr, input logic hold,
                                    input logic held_bit, input logic live_bit);
    return ~clr & (hold ? held_bit : live_bit);
  endfunction

endpackage

// File: rtl/sersw_sync.sv
module sersw_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic [WIDTH-1:0] prev_o
);
  localparam int LAST = STAGES - 1;

  logic [WIDTH-1:0] chain_q [STAGES];
  logic [WIDTH-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= '0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= chain_q[LAST];
  end

  assign sync_o = chain_q[LAST];
  assign prev_o = prev_q;
endmodule

// File: rtl/sersw_shreg.sv
module sersw_shreg #(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step_i,
  input  logic              bit_i,
  output logic [NUM_CH-1:0] stages_o
);
  localparam int TOP = NUM_CH - 1;

  function automatic logic [NUM_CH-1:0] shift_in(input logic [NUM_CH-1:0] cur,
                                                  input logic b);
    return {cur[TOP-1:0], b};
  endfunction

  logic [NUM_CH-1:0] stages_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stages_q <= '0;
    else if (step_i) stages_q <= shift_in(stages_q, bit_i);
  end

  assign stages_o = stages_q;
endmodule

// File: rtl/sersw_hold.sv
module sersw_hold
  import sersw_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_i,
  input  logic              clear_i,
  input  logic [NUM_CH-1:0] stages_i,
  output logic [NUM_CH-1:0] sw_o
);
  logic [NUM_CH-1:0] held_q;

  // one independent latch cell per channel
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       held_q[ch] <= 1'b0;
      else if (clear_i) held_q[ch] <= 1'b0;
      else if (!hold_i) held_q[ch] <= stages_i[ch];
    end
    assign sw_o[ch] = chan_cmd(clear_i, hold_i, held_q[ch], stages_i[ch]);
  end
endmodule

// File: rtl/sersw_ctrl.sv
module sersw_ctrl
  import sersw_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic              latch_hold_i,
  input  logic              clear_i,
  output logic [NUM_CH-1:0] sw_o,
  output logic              sdo_o
);
  localparam int TOP = NUM_CH - 1;

  logic [IN_COUNT-1:0] raw_in;
  logic [IN_COUNT-1:0] syn_in;
  logic [IN_COUNT-1:0] syn_prev;

  // named internal events, also used by the bound checker
  logic              sclk_rise;
  logic              data_s;
  logic              hold_s;
  logic              clr_s;
  logic [NUM_CH-1:0] shreg_q;

  always_comb begin
    raw_in           = '0;
    raw_in[IN_SCLK]  = sclk_i;
    raw_in[IN_SDATA] = sdata_i;
    raw_in[IN_HOLD]  = latch_hold_i;
    raw_in[IN_CLEAR] = clear_i;
  end

  sersw_sync #(.WIDTH(IN_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .async_i(raw_in),
    .sync_o (syn_in),
    .prev_o (syn_prev)
  );

  assign sclk_rise = rose(syn_in[IN_SCLK], syn_prev[IN_SCLK]);
  assign data_s    = syn_in[IN_SDATA];
  assign hold_s    = syn_in[IN_HOLD];
  assign clr_s     = syn_in[IN_CLEAR];

  sersw_shreg #(.NUM_CH(NUM_CH)) u_shreg (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_i  (sclk_rise),
    .bit_i   (data_s),
    .stages_o(shreg_q)
  );

  sersw_hold #(.NUM_CH(NUM_CH)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n),
    .hold_i  (hold_s),
    .clear_i (clr_s),
    .stages_i(shreg_q),
    .sw_o    (sw_o)
  );

  assign sdo_o = shreg_q[TOP];
endmodule

// File: rtl/sersw_ctrl_chk.sv
module sersw_ctrl_chk #(
  parameter int NUM_CH = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sclk_rise,
  input logic              le_s,
  input logic              clr_s,
  input logic [NUM_CH-1:0] shreg,
  input logic [NUM_CH-1:0] sw_o,
  input logic              sdo_o
);
  localparam int TOP = NUM_CH - 1;

  AST_SHIFT_ONLY_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk_rise |=> $stable(shreg)); // R1

  AST_SHIFT_TOWARD_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> shreg[TOP:1] == $past(shreg[TOP-1:0])); // R2

  AST_TRANSPARENT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!le_s && !clr_s) |-> sw_o == shreg); // R3

  AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (le_s && !clr_s) ##1 (le_s && !clr_s) |-> $stable(sw_o)); // R4

  AST_CLEAR_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    clr_s |-> sw_o == '0); // R5

  AST_CLEAR_EMPTIES_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_s && le_s) ##1 (!clr_s && le_s) |-> sw_o == '0); // R6

  AST_SDO_FOLLOWS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> sdo_o == $past(shreg[TOP-1])); // R7
endmodule

bind sersw_ctrl sersw_ctrl_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sclk_rise(sclk_rise),
  .le_s     (hold_s),
  .clr_s    (clr_s),
  .shreg    (shreg_q),
  .sw_o     (sw_o),
  .sdo_o    (sdo_o)
);

// File: tb/sersw_ctrl_tb.sv
module sersw_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       sdata = 1'b0;
  logic       hold = 1'b1;
  logic       clr = 1'b0;
  logic [7:0] sw_a, sw_b;
  logic       sdo_a, sdo_b;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int last_change = 0;
  bit live = 1'b0;
  string cur_req = "R8";

  // behavioural reference state
  logic [7:0] a_sr = '0, b_sr = '0, a_held = '0, b_held = '0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sersw_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdata),
    .latch_hold_i(hold), .clear_i(clr), .sw_o(sw_a), .sdo_o(sdo_a));

  sersw_ctrl u_tail (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdata_i(sdo_a),
    .latch_hold_i(hold), .clear_i(clr), .sw_o(sw_b), .sdo_o(sdo_b));

  function automatic logic [7:0] exp_sw(input logic [7:0] sr, input logic [7:0] held);
    if (clr) return 8'h00;
    return hold ? held : sr;
  endfunction

  task automatic check8(input string req, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic mark();
    last_change = cyc;
    if (clr) begin
      a_held = '0;
      b_held = '0;
    end else if (!hold) begin
      a_held = a_sr;
      b_held = b_sr;
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdata = b;
    mark();
    settle(4);
    sclk = 1'b1;
    b_sr = {b_sr[6:0], a_sr[7]};
    a_sr = {a_sr[6:0], b};
    mark();
    settle(4);
    sclk = 1'b0;
    mark();
  endtask

  task automatic send_word(input logic [15:0] w, input int nbits);
    for (int i = nbits - 1; i >= 0; i--) send_bit(w[i]);
    settle(5);
  endtask

  // per-clock comparison against the reference once inputs have settled (R9)
  always @(negedge clk) begin
    if (live && (cyc - last_change >= 4)) begin
      check8(cur_req, "sw A", sw_a, exp_sw(a_sr, a_held));
      check8(cur_req, "sw B", sw_b, exp_sw(b_sr, b_held));
      check8("R7", "sdo A", {7'd0, sdo_a}, {7'd0, a_sr[7]});
      check8("R7", "sdo B", {7'd0, sdo_b}, {7'd0, b_sr[7]});
    end
  end

  initial begin
    #(200000 * 4);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    settle(3);
    rst_n = 1'b1;
    settle(6);
    // R8: reset state
    check8("R8", "reset sw A", sw_a, 8'h00);
    check8("R8", "reset sdo", {7'd0, sdo_a}, 8'h00);
    mark();
    live = 1'b1;

    // R4: load 16 bits through the chain while holding
    cur_req = "R4";
    send_word(16'hA53C, 16);
    check8("R4", "hold after load A", sw_a, 8'h00);
    check8("R4", "hold after load B", sw_b, 8'h00);

    // R2 / R7 / R3: release hold, byte split across the chain
    cur_req = "R3";
    hold = 1'b0;
    mark();
    settle(5);
    check8("R2", "tail byte (first bits sent)", sw_b, 8'hA5);
    check8("R7", "head byte (last bits sent)", sw_a, 8'h3C);
    check8("R2", "first bit on SW7 of tail", {7'd0, sw_b[7]}, 8'h01);

    // R3: transparent while shifting
    send_word(16'h0005, 3);
    check8("R3", "transparent A", sw_a, 8'hE5);

    // R1: data toggles without a serial clock edge
    cur_req = "R1";
    for (int i = 0; i < 6; i++) begin
      sdata = ~sdata;
      mark();
      settle(5);
    end
    check8("R1", "no shift on data toggles", sw_a, 8'hE5);

    // R4: capture then shift under hold
    cur_req = "R4";
    hold = 1'b1;
    mark();
    settle(5);
    send_word(16'h0013, 5);
    check8("R4", "frozen A under shifting", sw_a, 8'hE5);
    check8("R7", "sdo tracks register under hold", {7'd0, sdo_a}, {7'd0, a_sr[7]});

    // R5 then R6 with hold high
    cur_req = "R5";
    clr = 1'b1;
    mark();
    settle(5);
    check8("R5", "clear under hold A", sw_a, 8'h00);
    check8("R5", "clear under hold B", sw_b, 8'h00);
    cur_req = "R6";
    clr = 1'b0;
    mark();
    settle(6);
    check8("R6", "latch emptied by clear", sw_a, 8'h00);
    hold = 1'b0;
    mark();
    settle(5);
    check8("R6", "register kept through clear", sw_a, a_sr);

    // R5: clear with hold low, shifting during clear
    cur_req = "R5";
    clr = 1'b1;
    mark();
    send_word(16'h0006, 4);
    check8("R5", "clear overrides shifting", sw_a, 8'h00);
    cur_req = "R6";
    clr = 1'b0;
    mark();
    settle(5);
    check8("R6", "follow after clear release", sw_a, a_sr);
    check8("R6", "tail follow after clear", sw_b, b_sr);

    live = 1'b0;
    settle(2);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule